// File: doc/BRIEF.md
# Partial-word caching link compressor

This block carries 64-bit words across a 48-line link by splitting each word into three parts. The 44 low-order bits always travel on the link unchanged. The next 3 bits select one of 8 entries in a small tag store. The top 17 bits are the tag, and they tend to change rarely. A transmitter and a receiver each hold a copy of the tag store, and both copies are kept identical. When the transmitter's entry already holds the word's tag, only the low bits, the index and a set hit flag cross the link, in a single beat. Otherwise the hit flag is clear and the tag follows in a second beat. Both copies then write that tag into the indexed entry.

Words enter through a valid/ready handshake. The transmitter drops ready while a tail beat is pending. The link is a registered 48-bit data bus with one beat strobe. The receiver rebuilds each word and presents it with a one-cycle valid pulse once all of its bits are known. The top module wires the transmitter and receiver back to back and exposes the link so that its beats can be observed.

Top module: `pwc_link_top`

## Requirements
- R1: The cycle after a word is accepted (in_valid and in_ready high at a clock edge), link_vld is high and link_data[43:0] equals the word's bits [43:0].
- R2: In that head beat, link_data[46:44] equals the word's bits [46:44], which select one of 8 tag entries.
- R3: In the head beat, link_data[47] is 1 exactly when the selected entry is valid and holds the word's bits [63:47].
- R4: A word that hits uses a single beat. in_ready stays high in the cycle its head beat is on the link, and link_vld is low the cycle after that unless a new word was accepted.
- R5: A word that misses is followed in the next cycle by a tail beat. In the tail beat, link_data[16:0] carries the word's bits [63:47] and link_data[47:17] is zero. in_ready is low in the cycle the head beat is on the link.
- R6: A miss writes the word's bits [63:47] into the indexed entry of both copies. A later word with the same bits [63:44] then hits and is rebuilt correctly by the receiver.
- R7: Reset marks all 8 entries invalid. The first lookup of each index after reset misses, even when the word's upper bits are all zero.
- R8: out_valid pulses high for one cycle per word, with out_data equal to the accepted word. The pulse comes in the cycle after the head beat for a hit, and in the cycle after the tail beat for a miss. Words leave in the order they were accepted.
- R9: A miss whose tag differs from the stored one replaces only the indexed entry. The old tag then misses at that index, and the other entries keep their contents.
- R10: While no word is accepted and no tail beat is due, link_vld and out_valid stay low and the tag stores do not change. in_data is ignored while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Word to send |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Transmitter can take a word this cycle |
| link_data | output | 48 | Link lines: head beat or tail beat |
| link_vld | output | 1 | A beat is on link_data |
| out_data | output | 64 | Rebuilt word |
| out_valid | output | 1 | out_data holds a rebuilt word for this cycle |

## Verification
The assertions assume that the link is driven only by this transmitter, so that a head beat with a clear hit flag is always the next beat before a tail. They also assume that in_data is sampled only at an accepting edge, so that the low-bit and index properties compare link_data with in_data one cycle back. The stimulus changes inputs only on falling edges and holds in_valid with a fixed word until in_ready has been seen high. It never drives unknown values, and it toggles in_data freely only while in_valid is low.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
  // Which beat of a word the link side is handling.
  typedef enum logic {
    BEAT_HEAD = 1'b0,
    BEAT_TAIL = 1'b1
  } beat_e;
endpackage

// File: rtl/pwc_tag_store.sv
`timescale 1ns/1ps
// Tag store: one write port, asynchronous read (maps onto LUT RAM),
// per-entry valid bits in flops so reset can clear them in one cycle.
module pwc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  // Data array has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_tag   = mem[rd_idx];
  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/pwc_tx.sv
`timescale 1ns/1ps
// Transmit side: looks the word's tag up, emits a head beat and,
// on a miss, a tail beat carrying the tag in the following cycle.
module pwc_tx
  import pwc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LOW_W  = 44,
  parameter int IDX_W  = 3,
  parameter int LINK_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [LINK_W-1:0] link_data,
  output logic              link_vld
);
  localparam int TAG_W   = WORD_W - LOW_W - IDX_W;
  localparam int HIT_POS = LOW_W + IDX_W;

  beat_e             state_q;
  logic [TAG_W-1:0]  tail_q;
  logic [LOW_W-1:0]  w_low;
  logic [IDX_W-1:0]  w_idx;
  logic [TAG_W-1:0]  w_tag;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid;
  logic              hit;
  logic              accept;
  logic [LINK_W-1:0] head_beat;
  logic [LINK_W-1:0] tail_beat;

  assign w_low = in_data[LOW_W-1:0];
  assign w_idx = in_data[LOW_W +: IDX_W];
  assign w_tag = in_data[WORD_W-1 -: TAG_W];

  assign in_ready = (state_q == BEAT_HEAD);
  assign accept   = in_valid && in_ready;
  assign hit      = rd_valid && (rd_tag == w_tag);

  pwc_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept && !hit),
    .wr_idx   (w_idx),
    .wr_tag   (w_tag),
    .rd_idx   (w_idx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid)
  );

  always_comb begin
    head_beat                  = '0;
    head_beat[LOW_W-1:0]       = w_low;
    head_beat[LOW_W +: IDX_W]  = w_idx;
    head_beat[HIT_POS]         = hit;
    tail_beat                  = '0;
    tail_beat[TAG_W-1:0]       = tail_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BEAT_HEAD;
      tail_q    <= '0;
      link_data <= '0;
      link_vld  <= 1'b0;
    end else begin
      link_vld <= 1'b0;
      case (state_q)
        BEAT_HEAD: begin
          if (accept) begin
            link_data <= head_beat;
            link_vld  <= 1'b1;
            if (!hit) begin
              tail_q  <= w_tag;
              state_q <= BEAT_TAIL;
            end
          end
        end
        BEAT_TAIL: begin
          link_data <= tail_beat;
          link_vld  <= 1'b1;
          state_q   <= BEAT_HEAD;
        end
        default: state_q <= BEAT_HEAD;
      endcase
    end
  end
endmodule

// File: rtl/pwc_rx.sv
`timescale 1ns/1ps
// Receive side: rebuilds the word from a head beat and either its own
// tag copy (hit) or the following tail beat (miss), updating the copy.
module pwc_rx
  import pwc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LOW_W  = 44,
  parameter int IDX_W  = 3,
  parameter int LINK_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINK_W-1:0] link_data,
  input  logic              link_vld,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);
  localparam int TAG_W   = WORD_W - LOW_W - IDX_W;
  localparam int HIT_POS = LOW_W + IDX_W;

  beat_e            state_q;
  logic [LOW_W-1:0] low_q;
  logic [IDX_W-1:0] idx_q;
  logic [LOW_W-1:0] b_low;
  logic [IDX_W-1:0] b_idx;
  logic             b_hit;
  logic [TAG_W-1:0] b_tag;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_valid;
  logic [TAG_W-1:0] local_tag;
  logic             fill;

  assign b_low = link_data[LOW_W-1:0];
  assign b_idx = link_data[LOW_W +: IDX_W];
  assign b_hit = link_data[HIT_POS];
  assign b_tag = link_data[TAG_W-1:0];

  assign fill      = link_vld && (state_q == BEAT_TAIL);
  assign local_tag = rd_valid ? rd_tag : '0;

  pwc_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (fill),
    .wr_idx   (idx_q),
    .wr_tag   (b_tag),
    .rd_idx   (b_idx),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BEAT_HEAD;
      low_q     <= '0;
      idx_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        BEAT_HEAD: begin
          if (link_vld) begin
            if (b_hit) begin
              out_data  <= {local_tag, b_idx, b_low};
              out_valid <= 1'b1;
            end else begin
              low_q   <= b_low;
              idx_q   <= b_idx;
              state_q <= BEAT_TAIL;
            end
          end
        end
        BEAT_TAIL: begin
          if (link_vld) begin
            out_data  <= {b_tag, idx_q, low_q};
            out_valid <= 1'b1;
            state_q   <= BEAT_HEAD;
          end
        end
        default: state_q <= BEAT_HEAD;
      endcase
    end
  end
endmodule

// File: rtl/pwc_link_top.sv
`timescale 1ns/1ps
// Transmitter and receiver joined by the registered link.
module pwc_link_top #(
  parameter int WORD_W = 64,
  parameter int LOW_W  = 44,
  parameter int IDX_W  = 3,
  parameter int LINK_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [LINK_W-1:0] link_data,
  output logic              link_vld,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);
  pwc_tx #(
    .WORD_W (WORD_W),
    .LOW_W  (LOW_W),
    .IDX_W  (IDX_W),
    .LINK_W (LINK_W)
  ) tx_i (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .link_data (link_data),
    .link_vld  (link_vld)
  );

  pwc_rx #(
    .WORD_W (WORD_W),
    .LOW_W  (LOW_W),
    .IDX_W  (IDX_W),
    .LINK_W (LINK_W)
  ) rx_i (
    .clk       (clk),
    .rst       (rst),
    .link_data (link_data),
    .link_vld  (link_vld),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/pwc_link_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the link pair.
module pwc_link_chk #(
  parameter int WORD_W = 64,
  parameter int LOW_W  = 44,
  parameter int IDX_W  = 3,
  parameter int LINK_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LINK_W-1:0] link_data,
  input logic              link_vld,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid
);
  localparam int TAG_W   = WORD_W - LOW_W - IDX_W;
  localparam int HIT_POS = LOW_W + IDX_W;

  logic             tail_due;
  logic [LOW_W-1:0] head_low;
  logic             head_seen;
  logic             head_hit;
  logic             head_miss;
  logic             took;

  assign head_seen = link_vld && !tail_due;
  assign head_hit  = head_seen && link_data[HIT_POS];
  assign head_miss = head_seen && !link_data[HIT_POS];
  assign took      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_due <= 1'b0;
      head_low <= '0;
    end else begin
      tail_due <= head_miss;
      if (head_seen) head_low <= link_data[LOW_W-1:0];
    end
  end

  a_r1_low_bits: assert property (@(posedge clk) disable iff (rst)
    took |=> (link_vld && link_data[LOW_W-1:0] == $past(in_data[LOW_W-1:0])));

  a_r2_index: assert property (@(posedge clk) disable iff (rst)
    took |=> (link_data[LOW_W +: IDX_W] == $past(in_data[LOW_W +: IDX_W])));

  a_r4_hit_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    head_hit |-> in_ready);

  a_r5_miss_drops_ready: assert property (@(posedge clk) disable iff (rst)
    head_miss |-> !in_ready);

  a_r5_tail_follows: assert property (@(posedge clk) disable iff (rst)
    head_miss |=> link_vld);

  a_r5_tail_clean: assert property (@(posedge clk) disable iff (rst)
    tail_due |-> (link_data[LINK_W-1:TAG_W] == '0));

  a_r8_hit_out: assert property (@(posedge clk) disable iff (rst)
    head_hit |=> out_valid);

  a_r8_miss_waits: assert property (@(posedge clk) disable iff (rst)
    head_miss |=> !out_valid);

  a_r8_tail_out: assert property (@(posedge clk) disable iff (rst)
    tail_due |=> out_valid);

  a_r8_low_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[LOW_W-1:0] == head_low));

  a_r10_link_quiet: assert property (@(posedge clk) disable iff (rst)
    (!took && !head_miss) |=> !link_vld);

  a_r10_out_quiet: assert property (@(posedge clk) disable iff (rst)
    !link_vld |=> !out_valid);
endmodule

bind pwc_link_top pwc_link_chk #(
  .WORD_W (WORD_W),
  .LOW_W  (LOW_W),
  .IDX_W  (IDX_W),
  .LINK_W (LINK_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .link_data (link_data),
  .link_vld  (link_vld),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/pwc_link_top_tb_top.sv
`timescale 1ns/1ps
module pwc_link_top_tb_top;
  localparam int NSTREAM = 48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] link_data;
  logic        link_vld;
  logic [63:0] out_data;
  logic        out_valid;

  int n_checks = 0;
  int n_err = 0;
  bit timed_out = 1'b0;

  // Bench model of the tag store, kept from the requirements.
  bit          mv [8];
  logic [16:0] mt [8];
  logic [31:0] lcg_q = 32'h1234_5678;

  // Stream capture.
  bit          mon_en = 1'b0;
  int          rx_cnt = 0;
  int          beat_cnt = 0;
  logic [63:0] rx_log [64];
  logic [63:0] tx_log [NSTREAM];

  always #2 clk = ~clk;

  pwc_link_top dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .link_data (link_data),
    .link_vld  (link_vld),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (rx_cnt < 64) rx_log[rx_cnt] = out_data;
        rx_cnt++;
      end
      if (link_vld) beat_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [16:0] tg, input logic [2:0] ix, input logic [43:0] lo);
    return {tg, ix, lo};
  endfunction

  task automatic rnd(output logic [43:0] v);
    lcg_q = lcg_q * 32'd1664525 + 32'd1013904223;
    v[43:32] = lcg_q[27:16];
    lcg_q = lcg_q * 32'd1664525 + 32'd1013904223;
    v[31:0] = lcg_q;
  endtask

  function automatic bit model_hit(input logic [63:0] w);
    return mv[w[46:44]] && (mt[w[46:44]] == w[63:47]);
  endfunction

  task automatic model_fill(input logic [63:0] w);
    mv[w[46:44]] = 1'b1;
    mt[w[46:44]] = w[63:47];
  endtask

  // One word, checked beat by beat. Called and returns at a falling edge.
  task automatic send_check(input logic [63:0] w, input bit want_hit);
    bit eh;
    eh = model_hit(w);
    check(eh == want_hit, "R3 (bench plan)", 64'(eh), 64'(want_hit));
    check(in_ready == 1'b1, "R4 ready before word", 64'(in_ready), 64'd1);
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~w;
    check(link_vld == 1'b1, "R1 head beat present", 64'(link_vld), 64'd1);
    check(link_data[43:0] == w[43:0], "R1 low bits", 64'(link_data[43:0]), 64'(w[43:0]));
    check(link_data[46:44] == w[46:44], "R2 index", 64'(link_data[46:44]), 64'(w[46:44]));
    check(link_data[47] == eh, "R3 hit flag", 64'(link_data[47]), 64'(eh));
    check(out_valid == 1'b0, "R8 no early output", 64'(out_valid), 64'd0);
    if (eh) begin
      check(in_ready == 1'b1, "R4 ready held on hit", 64'(in_ready), 64'd1);
    end else begin
      check(in_ready == 1'b0, "R5 ready low on miss", 64'(in_ready), 64'd0);
      model_fill(w);
      @(negedge clk);
      check(link_vld == 1'b1, "R5 tail beat present", 64'(link_vld), 64'd1);
      check(link_data[16:0] == w[63:47], "R5 tail tag", 64'(link_data[16:0]), 64'(w[63:47]));
      check(link_data[47:17] == '0, "R5 tail upper zero", 64'(link_data[47:17]), 64'd0);
      check(out_valid == 1'b0, "R8 wait for tail", 64'(out_valid), 64'd0);
    end
    @(negedge clk);
    check(out_valid == 1'b1, "R8 output valid", 64'(out_valid), 64'd1);
    check(out_data == w, "R8 output word", out_data, w);
    check(link_vld == 1'b0, eh ? "R4 single beat" : "R5 two beats only", 64'(link_vld), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 one-cycle pulse", 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'd1);
    check(link_vld == 1'b0, "R10 link idle after reset", 64'(link_vld), 64'd0);
    check(out_valid == 1'b0, "R10 output idle after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_cold_then_hit;
    logic [43:0] lo;
    rnd(lo);
    send_check(mk(17'h0, 3'd0, lo), 1'b0);       // R7: zero tag still misses
    rnd(lo);
    send_check(mk(17'h0, 3'd0, lo), 1'b1);       // R6: now hits
    rnd(lo);
    send_check(mk(17'h1ABCD, 3'd5, lo), 1'b0);   // R7 at another index
    rnd(lo);
    send_check(mk(17'h1ABCD, 3'd5, lo), 1'b1);   // R6
  endtask

  task automatic t_replace;
    logic [43:0] lo;
    rnd(lo);
    send_check(mk(17'h00F0F, 3'd5, lo), 1'b0);   // R9: new tag replaces
    rnd(lo);
    send_check(mk(17'h1ABCD, 3'd5, lo), 1'b0);   // R9: old tag gone
    rnd(lo);
    send_check(mk(17'h0, 3'd0, lo), 1'b1);       // R9: index 0 untouched
  endtask

  task automatic t_all_indexes;
    logic [43:0] lo;
    for (int i = 0; i < 8; i++) begin
      rnd(lo);
      send_check(mk(17'h10000 | 17'(i * 3), 3'(i), lo), 1'b0); // R2 R7
    end
    for (int i = 7; i >= 0; i--) begin
      rnd(lo);
      send_check(mk(17'h10000 | 17'(i * 3), 3'(i), lo), 1'b1); // R6 R2
    end
  endtask

  task automatic t_idle;
    logic [43:0] lo;
    for (int i = 0; i < 6; i++) begin
      rnd(lo);
      in_data = {20'hFFFFF, lo};
      @(negedge clk);
      check(link_vld == 1'b0, "R10 no beat while idle", 64'(link_vld), 64'd0);
      check(out_valid == 1'b0, "R10 no output while idle", 64'(out_valid), 64'd0);
    end
    rnd(lo);
    send_check(mk(17'h10000 | 17'd21, 3'd7, lo), 1'b1); // R10 store unchanged
  endtask

  task automatic t_stream;
    logic [43:0] lo;
    logic [63:0] w;
    int misses;
    int bad;
    misses = 0;
    rx_cnt = 0;
    beat_cnt = 0;
    mon_en = 1'b1;
    for (int k = 0; k < NSTREAM; k++) begin
      rnd(lo);
      w = mk(17'h05550 + 17'(lo[5:4]), lo[2:0], lo);
      tx_log[k] = w;
      if (!model_hit(w)) begin
        misses++;
        model_fill(w);
      end
      in_data  = w;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    mon_en = 1'b0;
    check(rx_cnt == NSTREAM, "R8 stream word count", 64'(rx_cnt), 64'(NSTREAM));
    check(beat_cnt == NSTREAM + misses, "R4 R5 stream beat count", 64'(beat_cnt), 64'(NSTREAM + misses));
    bad = 0;
    for (int k = 0; k < NSTREAM && k < rx_cnt; k++) begin
      if (rx_log[k] != tx_log[k]) begin
        if (bad == 0) check(1'b0, "R8 stream order", rx_log[k], tx_log[k]);
        bad++;
      end
    end
    if (bad == 0) check(1'b1, "R8 stream order", 64'd0, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      mv[i] = 1'b0;
      mt[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_cold_then_hit();
        t_replace();
        t_all_indexes();
        t_idle();
        t_stream();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule